// File: doc/BRIEF.md
# Packet Page Allocator and Queue Sequencer

This block owns a small pool of fixed-size packet pages (four by default) and keeps track of which ones are in use with a bitmap. A CPU-side register file hands it 3-bit commands: allocate a page for transmission, release a page, reset the allocator, pop the receive queue, pop and release, enqueue a page for transmission, and clear the transmit queues. Three short queues of page numbers sit beside the bitmap. Transmit holds pages waiting to be sent, completion holds pages that were sent and not yet acknowledged, and receive holds pages filled by the receive path.

Allocation always picks the lowest-numbered free page. A transmit allocation that finds the pool full reports the failure code 0x80 and stays pending. Every later page release retries it automatically. The receive path asks for pages through a request/grant pair and is refused while reception is armed and the pool is full. When transmission is enabled, a two-state sequencer (`SQ_IDLE`, `SQ_SEND`) drains the transmit queue one page per cycle. In auto-release mode it frees each sent page; otherwise it records the page on the completion queue. While the sequencer is in `SQ_SEND`, the block reports busy and drops incoming commands.

Sequencer transitions:
- `SQ_IDLE -> SQ_SEND`: transmission is enabled, the transmit queue is non-empty, and no command is presented.
- `SQ_SEND -> SQ_SEND`: more than one entry remains in the transmit queue.
- `SQ_SEND -> SQ_IDLE`: the last entry has been sent.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset the following hold.
  - No page is in use.
  - The allocation result reads 0.
  - Both queue heads read 0x80.
  - The pool-size output reads 4.
  - The block is not busy and receive is ready.
- R2: Command code 1 (`cmd_op`, which carries bits 7:5 of the command byte) allocates the lowest-numbered free page and reports its number as the allocation result. When no page is free, the result is 0x80.
- R3: While the allocation result is 0x80 after a failed code-1 allocation, any page release immediately re-runs the allocation. The result then becomes the lowest free page.
- R4: Command code 2 frees every page, empties all three queues and sets the allocation result to 0.
- R5: Command code 3 removes the receive-queue head without freeing it. Command code 4 frees the receive-queue head page and then removes it. On an empty receive queue, both codes change nothing.
- R6: Command code 5 frees the page named by `pkt_num`.
- R7: Command code 6 appends `pkt_num` to the transmit queue. An append to a full queue (4 entries) is ignored.
- R8: When transmission is enabled and the transmit queue holds pages, every queued page is presented on `tx_send_*` in queue order, one per cycle, and the queue is then emptied. Each sent page is freed in auto-release mode, or appended to the completion queue otherwise. `done_ack` removes the completion-queue head.
- R9: Command code 7 empties the transmit queue and the completion queue.
- R10: `rx_ready` is low exactly when reception is enabled, not in soft reset, and all pages are in use. A receive request with a free page is granted the lowest free page, which joins the receive queue.
- R11: While the sequencer sends, `cmd_busy` is high and presented commands have no effect.
- R12: Command code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code (command byte bits 7:5) |
| pkt_num | input | 2 | Packet-number register value |
| tx_enable | input | 1 | Transmission enabled |
| auto_release | input | 1 | Free pages after sending |
| rx_enable | input | 1 | Reception enabled |
| rx_soft_reset | input | 1 | Receive soft reset active |
| done_ack | input | 1 | Remove the completion-queue head |
| rx_req | input | 1 | Receive path asks for a page |
| rx_grant | output | 1 | Page granted this cycle |
| rx_page | output | 2 | Granted page number |
| rx_ready | output | 1 | Receive path may deliver |
| cmd_busy | output | 1 | Sequencer busy, commands dropped |
| alloc_result | output | 8 | Last allocation result, 0x80 = none |
| done_head | output | 8 | Completion-queue head, 0x80 = empty |
| rx_head | output | 8 | Receive-queue head, 0x80 = empty |
| pages_total | output | 8 | Pool size |
| pages_used | output | 8 | Count of pages in use |
| tx_send_valid | output | 1 | A page is being sent |
| tx_send_page | output | 2 | Page being sent |

## Verification
Allocation is exercised by filling the pool from empty, which separates lowest-free selection from any other order. A release is then swept across every page while an allocation is pending, so that each page in turn is reclaimed by the retry. The transmit path runs three times:
- with the queue filled to capacity plus one, which exposes a queue that accepts the extra entry;
- with auto-release on and off, which distinguishes freeing a sent page from recording it;
- with a command presented during sending, which shows whether commands are dropped while busy.

Receive grants are driven past exhaustion under each combination of enable and soft reset. The pop codes are applied to full and empty receive queues, which separates a pop from a pop with release.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_MMU_RST = 3'd2,
        OP_RX_POP  = 3'd3,
        OP_RX_FREE = 3'd4,
        OP_REL     = 3'd5,
        OP_TX_PUSH = 3'd6,
        OP_TX_CLR  = 3'd7
    } mmu_op_e;

    typedef enum logic {
        SQ_IDLE,
        SQ_SEND
    } seq_state_e;

    localparam logic [7:0] NO_PAGE = 8'h80;

endpackage

// File: rtl/pkt_page_pick.sv
module pkt_page_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] used,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/pkt_page_fifo.sv
module pkt_page_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         one_left
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  ent_q [DEPTH];
    logic [W-1:0]  ent_n [DEPTH];
    logic [CW-1:0] cnt_q, cnt_mid, cnt_n;

    always_comb begin
        ent_n   = ent_q;
        cnt_mid = cnt_q;
        if (pop && cnt_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) ent_n[i] = ent_q[i+1];
            ent_n[DEPTH-1] = '0;
            cnt_mid = cnt_q - CW'(1);
        end
        cnt_n = cnt_mid;
        if (push && cnt_mid != CW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == cnt_mid) ent_n[i] = push_data;
            end
            cnt_n = cnt_mid + CW'(1);
        end
        if (clr) begin
            cnt_n = '0;
            for (int i = 0; i < DEPTH; i++) ent_n[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_n;
            ent_q <= ent_n;
        end
    end

    assign head     = ent_q[0];
    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CW'(DEPTH));
    assign one_left = (cnt_q == CW'(1));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
    import pkt_page_pkg::*;
#(
    parameter int NUM_PAGES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [$clog2(NUM_PAGES)-1:0] pkt_num,
    input  logic                         tx_enable,
    input  logic                         auto_release,
    input  logic                         rx_enable,
    input  logic                         rx_soft_reset,
    input  logic                         done_ack,
    input  logic                         rx_req,
    output logic                         rx_grant,
    output logic [$clog2(NUM_PAGES)-1:0] rx_page,
    output logic                         rx_ready,
    output logic                         cmd_busy,
    output logic [7:0]                   alloc_result,
    output logic [7:0]                   done_head,
    output logic [7:0]                   rx_head,
    output logic [7:0]                   pages_total,
    output logic [7:0]                   pages_used,
    output logic                         tx_send_valid,
    output logic [$clog2(NUM_PAGES)-1:0] tx_send_page
);
    localparam int PW = $clog2(NUM_PAGES);

    seq_state_e state, state_n;
    mmu_op_e    op;
    logic [NUM_PAGES-1:0] used_q, used_n, used_mid, rel_mask;
    logic [7:0] result_q, result_n;
    logic       cmd_go, take, mmu_rst, tx_push, tx_clr, tx_pop, rx_pop, done_push;
    logic       pick_found;
    logic [PW-1:0] pick_idx;
    logic [PW-1:0] txq_head, rxq_head, doneq_head;
    logic txq_empty, txq_full, txq_one;
    logic rxq_empty, rxq_full, rxq_one;
    logic doneq_empty, doneq_full, doneq_one;
    logic unused_fifo_flags;

    assign op     = mmu_op_e'(cmd_op);
    assign cmd_go = cmd_valid && (state == SQ_IDLE);
    assign unused_fifo_flags = txq_full ^ rxq_one ^ doneq_one;

    pkt_page_pick #(.N(NUM_PAGES), .W(PW)) u_pick (
        .used(used_mid), .found(pick_found), .idx(pick_idx)
    );

    pkt_page_fifo #(.DEPTH(NUM_PAGES), .W(PW)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(mmu_rst || tx_clr),
        .push(tx_push), .push_data(pkt_num), .pop(tx_pop),
        .head(txq_head), .empty(txq_empty), .full(txq_full), .one_left(txq_one)
    );

    pkt_page_fifo #(.DEPTH(NUM_PAGES), .W(PW)) u_doneq (
        .clk(clk), .rst_n(rst_n), .clr(mmu_rst || tx_clr),
        .push(done_push), .push_data(txq_head), .pop(done_ack),
        .head(doneq_head), .empty(doneq_empty), .full(doneq_full), .one_left(doneq_one)
    );

    pkt_page_fifo #(.DEPTH(NUM_PAGES), .W(PW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(mmu_rst),
        .push(rx_grant), .push_data(pick_idx), .pop(rx_pop),
        .head(rxq_head), .empty(rxq_empty), .full(rxq_full), .one_left(rxq_one)
    );

    // pages freed this cycle by a command or by an auto-released send
    always_comb begin
        rel_mask = '0;
        if (state == SQ_SEND) begin
            if (auto_release) rel_mask[txq_head] = 1'b1;
        end else if (cmd_go) begin
            if (op == OP_REL) rel_mask[pkt_num] = 1'b1;
            else if (op == OP_RX_FREE && !rxq_empty) rel_mask[rxq_head] = 1'b1;
        end
    end

    assign used_mid = used_q & ~rel_mask;

    assign rx_ready = !(rx_enable && !rx_soft_reset && (&used_q));
    assign rx_grant = rx_req && (state == SQ_IDLE) && !cmd_valid && rx_enable &&
                      !rx_soft_reset && pick_found && !rxq_full;
    assign rx_page  = pick_idx;

    // next-state and command decode
    always_comb begin
        state_n   = state;
        result_n  = result_q;
        take      = 1'b0;
        mmu_rst   = 1'b0;
        tx_push   = 1'b0;
        tx_clr    = 1'b0;
        tx_pop    = 1'b0;
        rx_pop    = 1'b0;
        done_push = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (cmd_go) begin
                    unique case (op)
                        OP_NOP: begin
                        end
                        OP_ALLOC: begin
                            result_n = NO_PAGE;
                            if (pick_found) begin
                                result_n = 8'(pick_idx);
                                take     = 1'b1;
                            end
                        end
                        OP_MMU_RST: begin
                            mmu_rst  = 1'b1;
                            result_n = 8'h00;
                        end
                        OP_RX_POP, OP_RX_FREE: rx_pop = 1'b1;
                        OP_REL: begin
                        end
                        OP_TX_PUSH: tx_push = 1'b1;
                        OP_TX_CLR:  tx_clr  = 1'b1;
                    endcase
                end else if (tx_enable && !txq_empty) begin
                    state_n = SQ_SEND;
                end
            end
            SQ_SEND: begin
                tx_pop    = 1'b1;
                done_push = !auto_release && !doneq_full;
                if (txq_one) state_n = SQ_IDLE;
            end
        endcase
        if ((|rel_mask) && result_q == NO_PAGE && pick_found) begin
            result_n = 8'(pick_idx);
            take     = 1'b1;
        end
        if (rx_grant) take = 1'b1;
    end

    always_comb begin
        used_n = used_mid;
        if (take) used_n[pick_idx] = 1'b1;
        if (mmu_rst) used_n = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            used_q   <= '0;
            result_q <= 8'h00;
        end else begin
            state    <= state_n;
            used_q   <= used_n;
            result_q <= result_n;
        end
    end

    // outputs
    always_comb begin
        cmd_busy      = (state == SQ_SEND);
        tx_send_valid = (state == SQ_SEND);
        tx_send_page  = txq_head;
        alloc_result  = result_q;
        done_head     = doneq_empty ? NO_PAGE : 8'(doneq_head);
        rx_head       = rxq_empty ? NO_PAGE : 8'(rxq_head);
        pages_total   = 8'(NUM_PAGES);
        pages_used    = 8'h00;
        for (int i = 0; i < NUM_PAGES; i++) pages_used = pages_used + 8'(used_q[i]);
    end

    // R2
    alloc_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && op == OP_ALLOC && !(&used_q)) |=> (alloc_result != NO_PAGE));

    // R4
    mmu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && op == OP_MMU_RST) |=> (pages_used == 8'h00 && rx_head == NO_PAGE &&
                                          done_head == NO_PAGE && txq_empty));

    // R10
    rx_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_grant |-> (rx_ready && rx_enable && !cmd_busy));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && !auto_release) |=> $stable(pages_used));

    // R8
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && txq_one) |=> (txq_empty && !cmd_busy));
endmodule

// File: tb/pkt_page_mgr_test.sv
module pkt_page_mgr_test;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] pkt_num = 2'd0;
    logic tx_enable = 1'b0, auto_release = 1'b0, rx_enable = 1'b0, rx_soft_reset = 1'b0;
    logic done_ack = 1'b0, rx_req = 1'b0;
    logic rx_grant, rx_ready, cmd_busy, tx_send_valid;
    logic [1:0] rx_page, tx_send_page;
    logic [7:0] alloc_result, done_head, rx_head, pages_total, pages_used;

    pkt_page_mgr uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .pkt_num(pkt_num),
        .tx_enable(tx_enable), .auto_release(auto_release), .rx_enable(rx_enable),
        .rx_soft_reset(rx_soft_reset), .done_ack(done_ack), .rx_req(rx_req),
        .rx_grant(rx_grant), .rx_page(rx_page), .rx_ready(rx_ready), .cmd_busy(cmd_busy),
        .alloc_result(alloc_result), .done_head(done_head), .rx_head(rx_head),
        .pages_total(pages_total), .pages_used(pages_used),
        .tx_send_valid(tx_send_valid), .tx_send_page(tx_send_page)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    logic [3:0] m_used = 4'b0;
    int m_res = 0;
    int m_tx[4], m_txn = 0;
    int m_dn[4], m_dnn = 0;
    int m_rx[4], m_rxn = 0;
    int sent[64];
    int sent_n = 0, sent_seen = 0;

    always @(negedge clk) begin
        if (tx_send_valid && sent_n < 64) begin
            sent[sent_n] = int'(tx_send_page);
            sent_n++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int m_pick();
        for (int i = 0; i < 4; i++) if (!m_used[i]) return i;
        return -1;
    endfunction

    task automatic m_release(input int p);
        int q;
        m_used[p] = 1'b0;
        if (m_res == 128) begin
            q = m_pick();
            if (q >= 0) begin
                m_res = q;
                m_used[q] = 1'b1;
            end
        end
    endtask

    task automatic m_rx_shift();
        for (int i = 0; i < 3; i++) m_rx[i] = m_rx[i+1];
        m_rxn--;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " used"}, int'(pages_used), $countones(m_used));
        chk({tag, " result"}, int'(alloc_result), m_res);
        chk({tag, " done_head"}, int'(done_head), m_dnn > 0 ? m_dn[0] : 128);
        chk({tag, " rx_head"}, int'(rx_head), m_rxn > 0 ? m_rx[0] : 128);
        chk({tag, " rx_ready"}, int'(rx_ready), (rx_enable && !rx_soft_reset && m_used == 4'hF) ? 0 : 1);
    endtask

    task automatic m_drain(input string tag);
        for (int i = 0; i < m_txn; i++) begin
            chk({tag, " send order"}, sent_seen + i < sent_n ? sent[sent_seen + i] : -1, m_tx[i]);
            if (auto_release) m_release(m_tx[i]);
            else if (m_dnn < 4) begin
                m_dn[m_dnn] = m_tx[i];
                m_dnn++;
            end
        end
        sent_seen += m_txn;
        chk({tag, " send count"}, sent_n, sent_seen);
        m_txn = 0;
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 4 && !cmd_busy; k++) @(negedge clk);
        for (int k = 0; k < 12 && cmd_busy; k++) @(negedge clk);
    endtask

    task automatic cmd(input int code, input string tag);
        int q;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = code[2:0];
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        case (code)
            1: begin
                m_res = 128;
                q = m_pick();
                if (q >= 0) begin
                    m_res = q;
                    m_used[q] = 1'b1;
                end
            end
            2: begin
                m_used = 4'b0; m_txn = 0; m_dnn = 0; m_rxn = 0; m_res = 0;
            end
            3: if (m_rxn > 0) m_rx_shift();
            4: if (m_rxn > 0) begin
                m_release(m_rx[0]);
                m_rx_shift();
            end
            5: m_release(int'(pkt_num));
            6: if (m_txn < 4) begin
                m_tx[m_txn] = int'(pkt_num);
                m_txn++;
            end
            7: begin
                m_txn = 0; m_dnn = 0;
            end
            default: ;
        endcase
        if (tx_enable && m_txn > 0) begin
            wait_drain();
            m_drain(tag);
        end
        check_all(tag);
    endtask

    task automatic rxreq(input string tag);
        int q;
        bit exp_g;
        @(negedge clk);
        rx_req = 1'b1;
        #1;
        q = m_pick();
        exp_g = rx_enable && !rx_soft_reset && q >= 0 && m_rxn < 4;
        chk({tag, " grant"}, int'(rx_grant), int'(exp_g));
        if (exp_g) chk({tag, " grant page"}, int'(rx_page), q);
        @(posedge clk);
        @(negedge clk);
        rx_req = 1'b0;
        if (exp_g) begin
            m_used[q] = 1'b1;
            m_rx[m_rxn] = q;
            m_rxn++;
        end
        check_all(tag);
    endtask

    task automatic ack(input string tag);
        @(negedge clk);
        done_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        done_ack = 1'b0;
        if (m_dnn > 0) begin
            for (int i = 0; i < 3; i++) m_dn[i] = m_dn[i+1];
            m_dnn--;
        end
        check_all(tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 total", int'(pages_total), 4);
        chk("R1 busy", int'(cmd_busy), 0);
        check_all("R1");
        // R12 no-op
        cmd(0, "R12");
        // R2 fill the pool then fail
        for (int i = 0; i < 4; i++) cmd(1, "R2 alloc");
        cmd(1, "R2 full");
        chk("R2 fail code", int'(alloc_result), 128);
        // R3 retry on release, R6 release by number
        pkt_num = 2'd2;
        cmd(5, "R3 retry");
        chk("R3 retry page", int'(alloc_result), 2);
        pkt_num = 2'd1;
        cmd(5, "R6 release");
        chk("R6 used", int'(pages_used), 3);
        cmd(1, "R2 regrab");
        cmd(1, "R3 pend");
        for (int p = 0; p < 4; p++) begin
            pkt_num = 2'(p);
            cmd(5, "R3 sweep");
            chk("R3 sweep page", int'(alloc_result), p);
            cmd(1, "R3 repend");
        end
        // R4
        cmd(2, "R4");
        // R10 receive grants
        rx_enable = 1'b1;
        for (int i = 0; i < 5; i++) rxreq("R10 rx");
        chk("R10 not ready", int'(rx_ready), 0);
        rx_soft_reset = 1'b1;
        rxreq("R10 soft");
        rx_soft_reset = 1'b0;
        rx_enable = 1'b0;
        rxreq("R10 off");
        // R5 pops
        cmd(3, "R5 pop");
        cmd(4, "R5 popfree");
        cmd(4, "R5 popfree2");
        cmd(4, "R5 popfree3");
        cmd(3, "R5 empty pop");
        cmd(4, "R5 empty popfree");
        cmd(2, "R4 again");
        // R7 full queue, R8 in-order drain, R11 busy
        for (int i = 0; i < 4; i++) cmd(1, "R7 alloc");
        for (int i = 3; i >= 0; i--) begin
            pkt_num = 2'(i);
            cmd(6, "R7 push");
        end
        pkt_num = 2'd0;
        cmd(6, "R7 overflow");
        @(negedge clk);
        tx_enable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 busy", int'(cmd_busy), 1);
        cmd_valid = 1'b1;
        cmd_op = 3'd2;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_drain();
        m_drain("R8 drain");
        check_all("R11 dropped");
        for (int i = 0; i < 4; i++) ack("R8 ack");
        // R8 auto release
        cmd(2, "R4 clr");
        auto_release = 1'b1;
        cmd(1, "R8 alloc");
        pkt_num = 2'd0;
        cmd(6, "R8 autorel");
        for (int i = 0; i < 4; i++) cmd(1, "R8 fill");
        cmd(1, "R8 pend");
        pkt_num = 2'd3;
        cmd(6, "R8 autorel retry");
        chk("R8 retry page", int'(alloc_result), 3);
        // R9 clear queues
        auto_release = 1'b0;
        cmd(2, "R4 clr2");
        cmd(1, "R9 a");
        cmd(1, "R9 b");
        pkt_num = 2'd0;
        cmd(6, "R9 send0");
        tx_enable = 1'b0;
        pkt_num = 2'd1;
        cmd(6, "R9 queue1");
        cmd(7, "R9 clear");
        @(negedge clk);
        tx_enable = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 nothing sent", sent_n, sent_seen);
        chk("R9 idle", int'(cmd_busy), 0);
        check_all("R9 final");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule